// File: doc/BRIEF.md
# Hibernate Wake-up Controller

This block sits in the always-on domain of a chip and decides when the main supply is switched off and when it comes back. Software writes a request bit to put the system into hibernate. The block then moves its regulator-control pin to the "off" level, which turns off the external regulator, and holds the core reset low. While hibernating it watches a set of wake sources: an RTC alarm or periodic event, an event from the watchdog on the slow crystal clock, and rising or falling edges on one of two digital pins. It also watches an emergency input that forces a restart. When any enabled source fires, the block leaves hibernate by itself and drives the regulator back on. No software is involved in the exit. It releases the core reset once core power is reported good.

Each source that caused a wake sets its own sticky status bit. A separate flag records that the last restart came from hibernate. Software clears these bits only by writing ones to a clear register. Each pad has its own driver mode and polarity. Either pad can act as the regulator control, and the same pad can also be the falling-edge wake input.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset the block is active with all status bits zero and `core_rst_n` high. Pin 0 is open-drain and drives low, so `pin_oe[0]`=1 and `pin_out[0]`=0. Pin 1 is high impedance, so `pin_oe[1]`=0. Both pads have polarity 0 and pin 0 is the control pin.
- R2: A write to the control register (address 0) with bit 5 set, made while active, enters hibernate at that clock edge. At the same edge `in_hib` rises, the control pin moves to its off level and `core_rst_n` goes low.
- R3: In hibernate, the RTC event (enable at control bit 0) or the clock-watchdog event (enable at control bit 1) ends hibernate at the edge where it is sampled. It sets status bit 0 or bit 1 respectively. A source whose enable bit is clear has no effect.
- R4: The wake pin is chosen by control bit 4 (0 selects pin 0, 1 selects pin 1). The other pin is ignored. Control bit 2 enables rising edges and bit 3 enables falling edges, and both may be set. An edge passes a two-flop synchronizer, so hibernate ends at the third edge after the pin changes. The edge sets status bit 2 for a rising edge or bit 3 for a falling edge.
- R5: Status bits stay set until a one is written to the same bit position of the clear register (address 2). A set and a clear in the same cycle leave the bit set.
- R6: Every exit from hibernate sets the wake flag, which is status bit 4. Software clears it through bit 4 of the clear register.
- R7: The pad configuration register (address 1) holds pin 0 in bits [2:0] and pin 1 in bits [5:3]. In each field, bits [1:0] are the driver mode and the top bit is the polarity. The control pin drives level = polarity while the regulator is on, and the inverse level while hibernating.
- R8: Driver mode 0 is high impedance: `oe`=0. Mode 1 is open-drain: `out`=0 and `oe` equals the inverse of the level. Mode 2 is push-pull: `oe`=1 and `out` equals the level. A pad that is not the control pin has level 0.
- R9: After a wake, `core_rst_n` stays low until `core_pwr_ok` is sampled high. It is released at that edge.
- R10: A pulse on `emerg_wake` during hibernate ends hibernate whatever the enable bits are. It sets only the wake flag.
- R11: Wake sources seen outside hibernate set no status bit and change no state.
- R12: Control bit 6 selects which pad is the regulator control pin (0 selects pin 0, 1 selects pin 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Always-on domain reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 pad configuration, 2 write-one clear |
| reg_wdata | input | 7 | Register write data |
| rtc_evt | input | 1 | RTC alarm or periodic event |
| osc_wdog_evt | input | 1 | Slow-clock watchdog event |
| emerg_wake | input | 1 | Forced restart request |
| core_pwr_ok | input | 1 | Core supply reported restored |
| pin_in | input | 2 | Pad input levels |
| pin_out | output | 2 | Pad output levels |
| pin_oe | output | 2 | Pad output enables |
| core_rst_n | output | 1 | Core reset, active low |
| in_hib | output | 1 | High while in hibernate |
| status | output | 5 | Sticky bits: 0 RTC, 1 watchdog, 2 rise, 3 fall, 4 wake flag |

## Verification
Register writes, RTC, watchdog and emergency events, and the `core_pwr_ok` release all act at the single edge after they are driven. Their results are read at the following falling edge. Pin edges need three edges, because of two synchronizer stages and one history stage. The bench samples one and two edges after a pin change and expects the block still hibernating, then expects the exit at the third. The vector walk waits four cycles after each stimulus, so no result can be missed. The directed tests count exact cycles for every latency named above.

// File: rtl/hib_wake_pkg.sv
package hib_wake_pkg;

    localparam int HIB_NPIN  = 2;
    localparam int PSEL_W    = 1;
    localparam int REG_W     = 7;
    localparam int SRC_W     = 5;

    localparam int SRC_RTC   = 0;
    localparam int SRC_OSC   = 1;
    localparam int SRC_RISE  = 2;
    localparam int SRC_FALL  = 3;
    localparam int SRC_FLAG  = 4;

    localparam int BIT_REQ   = 5;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PCFG = 2'd1;
    localparam logic [1:0] ADDR_CLR  = 2'd2;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_HIB    = 2'd1,
        ST_WAKE   = 2'd2
    } hib_state_e;

    typedef enum logic [1:0] {
        DRV_HIZ = 2'd0,
        DRV_OD  = 2'd1,
        DRV_PP  = 2'd2,
        DRV_RSV = 2'd3
    } drv_mode_e;

    typedef struct packed {
        logic      pol;
        drv_mode_e mode;
    } pin_cfg_t;

    typedef struct packed {
        logic [PSEL_W-1:0] ctrl_pin;
        logic [PSEL_W-1:0] wake_pin;
        logic              fall_en;
        logic              rise_en;
        logic              osc_en;
        logic              rtc_en;
    } wake_cfg_t;

endpackage

// File: rtl/hib_pin_edge.sv
module hib_pin_edge #(
    parameter int NPIN        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] rise_o,
    output logic [NPIN-1:0] fall_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [CHAIN_W-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[CHAIN_W-2:0], pin_i[p]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise_o[p] =  sh_q[CHAIN_W-2] & ~sh_q[CHAIN_W-1];
        assign fall_o[p] = ~sh_q[CHAIN_W-2] &  sh_q[CHAIN_W-1];
    end

endmodule

// File: rtl/hib_pad_drive.sv
module hib_pad_drive
    import hib_wake_pkg::*;
#(
    parameter int NPIN = HIB_NPIN
) (
    input  pin_cfg_t [NPIN-1:0] cfg_i,
    input  logic [PSEL_W-1:0]   ctrl_sel_i,
    input  logic                reg_on_i,
    output logic [NPIN-1:0]     pad_out_o,
    output logic [NPIN-1:0]     pad_oe_o
);

    for (genvar p = 0; p < NPIN; p++) begin : g_pad
        logic level;

        always_comb begin
            if (ctrl_sel_i == PSEL_W'(p)) level = reg_on_i ? cfg_i[p].pol : ~cfg_i[p].pol;
            else                          level = 1'b0;
            unique case (cfg_i[p].mode)
                DRV_OD: begin
                    pad_out_o[p] = 1'b0;
                    pad_oe_o[p]  = ~level;
                end
                DRV_PP: begin
                    pad_out_o[p] = level;
                    pad_oe_o[p]  = 1'b1;
                end
                default: begin
                    pad_out_o[p] = 1'b0;
                    pad_oe_o[p]  = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl
    import hib_wake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                rtc_evt,
    input  logic                osc_wdog_evt,
    input  logic                emerg_wake,
    input  logic                core_pwr_ok,
    input  logic [HIB_NPIN-1:0] pin_in,
    output logic [HIB_NPIN-1:0] pin_out,
    output logic [HIB_NPIN-1:0] pin_oe,
    output logic                core_rst_n,
    output logic                in_hib,
    output logic [SRC_W-1:0]    status
);

    localparam int PCFG_W = $bits(pin_cfg_t);

    typedef struct packed {
        hib_state_e                st;
        wake_cfg_t                 cfg;
        pin_cfg_t [HIB_NPIN-1:0]   pcfg;
        logic [SRC_W-1:0]          sts;
    } regs_t;

    localparam pin_cfg_t PCFG0_RST = '{pol: 1'b0, mode: DRV_OD};
    localparam pin_cfg_t PCFGN_RST = '{pol: 1'b0, mode: DRV_HIZ};

    regs_t r_d, r_q;

    logic [HIB_NPIN-1:0] rise_w, fall_w;
    logic                wr_ctrl, wr_pcfg, wr_clr;
    logic [SRC_W-2:0]    src_hit;

    hib_pin_edge #(
        .NPIN        (HIB_NPIN),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    always_comb begin
        wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
        wr_pcfg = reg_we && (reg_addr == ADDR_PCFG);
        wr_clr  = reg_we && (reg_addr == ADDR_CLR);

        src_hit[SRC_RTC]  = rtc_evt      & r_q.cfg.rtc_en;
        src_hit[SRC_OSC]  = osc_wdog_evt & r_q.cfg.osc_en;
        src_hit[SRC_RISE] = rise_w[r_q.cfg.wake_pin] & r_q.cfg.rise_en;
        src_hit[SRC_FALL] = fall_w[r_q.cfg.wake_pin] & r_q.cfg.fall_en;

        r_d = r_q;

        if (wr_ctrl) begin
            r_d.cfg.rtc_en   = reg_wdata[0];
            r_d.cfg.osc_en   = reg_wdata[1];
            r_d.cfg.rise_en  = reg_wdata[2];
            r_d.cfg.fall_en  = reg_wdata[3];
            r_d.cfg.wake_pin = reg_wdata[4];
            r_d.cfg.ctrl_pin = reg_wdata[6];
        end

        if (wr_pcfg) begin
            for (int p = 0; p < HIB_NPIN; p++) begin
                r_d.pcfg[p] = reg_wdata[p*PCFG_W +: PCFG_W];
            end
        end

        if (wr_clr) r_d.sts = r_q.sts & ~reg_wdata[SRC_W-1:0];

        unique case (r_q.st)
            ST_ACTIVE: begin
                if (wr_ctrl && reg_wdata[BIT_REQ]) r_d.st = ST_HIB;
            end
            ST_HIB: begin
                if ((|src_hit) || emerg_wake) begin
                    r_d.st  = ST_WAKE;
                    r_d.sts = r_d.sts | {1'b1, src_hit};
                end
            end
            ST_WAKE: begin
                if (core_pwr_ok) r_d.st = ST_ACTIVE;
            end
            default: r_d.st = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_ACTIVE;
            r_q.cfg     <= '0;
            r_q.pcfg[0] <= PCFG0_RST;
            for (int p = 1; p < HIB_NPIN; p++) r_q.pcfg[p] <= PCFGN_RST;
            r_q.sts     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    hib_pad_drive #(
        .NPIN (HIB_NPIN)
    ) u_pad (
        .cfg_i      (r_q.pcfg),
        .ctrl_sel_i (r_q.cfg.ctrl_pin),
        .reg_on_i   (r_q.st != ST_HIB),
        .pad_out_o  (pin_out),
        .pad_oe_o   (pin_oe)
    );

    assign in_hib     = (r_q.st == ST_HIB);
    assign core_rst_n = (r_q.st == ST_ACTIVE);
    assign status     = r_q.sts;

    // R2
    hib_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_hib && core_rst_n && wr_ctrl && reg_wdata[BIT_REQ]) |=> in_hib);

    // R9
    core_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> $past(core_pwr_ok));

    // R6
    flag_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_hib) |-> status[SRC_FLAG]);

    // R11
    src_only_in_hib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SRC_RTC]) |-> $past(in_hib));

    for (genvar b = 0; b < SRC_W; b++) begin : g_sticky
        // R5
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status[b] && !(wr_clr && reg_wdata[b])) |=> status[b]);
    end

    for (genvar p = 0; p < HIB_NPIN; p++) begin : g_od
        // R8
        od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.pcfg[p].mode == DRV_OD) |-> !pin_out[p]);
    end

endmodule

// File: tb/sim_hib_wake_ctrl.sv
module sim_hib_wake_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [6:0] reg_wdata = 7'd0;
    logic       rtc_evt = 1'b0;
    logic       osc_wdog_evt = 1'b0;
    logic       emerg_wake = 1'b0;
    logic       core_pwr_ok = 1'b0;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_out, pin_oe;
    logic       core_rst_n, in_hib;
    logic [4:0] status;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hib_wake_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .rtc_evt      (rtc_evt),
        .osc_wdog_evt (osc_wdog_evt),
        .emerg_wake   (emerg_wake),
        .core_pwr_ok  (core_pwr_ok),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .core_rst_n   (core_rst_n),
        .in_hib       (in_hib),
        .status       (status)
    );

    // ctrl[7:0], stim[3:0], wake, status[4:0]
    // stim: 0 rtc, 1 wdog, 2 pin0 rise, 3 pin0 fall, 4 pin1 rise, 5 pin1 fall, 6 emergency
    localparam int NVEC = 12;
    localparam logic [17:0] VEC [NVEC] = '{
        {8'h01, 4'd0, 1'b1, 5'b10001},
        {8'h00, 4'd0, 1'b0, 5'b00000},
        {8'h02, 4'd1, 1'b1, 5'b10010},
        {8'h04, 4'd2, 1'b1, 5'b10100},
        {8'h08, 4'd2, 1'b0, 5'b00000},
        {8'h08, 4'd3, 1'b1, 5'b11000},
        {8'h1C, 4'd5, 1'b1, 5'b11000},
        {8'h1C, 4'd2, 1'b0, 5'b00000},
        {8'h14, 4'd4, 1'b1, 5'b10100},
        {8'h00, 4'd6, 1'b1, 5'b10000},
        {8'h01, 4'd1, 1'b0, 5'b00000},
        {8'h03, 4'd3, 1'b0, 5'b00000}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] pin_lvl);
        @(negedge clk);
        rst_n = 1'b0;
        pin_in = pin_lvl;
        core_pwr_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [6:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(2'b00);
        chk("R1 pin_oe", {6'd0, pin_oe}, 8'h01);
        chk("R1 pin_out", {6'd0, pin_out}, 8'h00);
        chk("R1 core_rst_n", {7'd0, core_rst_n}, 8'h01);
        chk("R1 in_hib", {7'd0, in_hib}, 8'h00);
        chk("R1 status", {3'd0, status}, 8'h00);

        // vector walk: R3 R4 R10
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] c;
            logic [3:0] s;
            logic [1:0] pre;
            c = VEC[i][17:10];
            s = VEC[i][9:6];
            pre = (s == 4'd3) ? 2'b01 : (s == 4'd5) ? 2'b10 : 2'b00;
            do_reset(pre);
            wr(2'd0, c[6:0] | 7'h20);
            chk("R2 vec entry", {7'd0, in_hib}, 8'h01);
            case (s)
                4'd0: rtc_evt = 1'b1;
                4'd1: osc_wdog_evt = 1'b1;
                4'd2: pin_in[0] = 1'b1;
                4'd3: pin_in[0] = 1'b0;
                4'd4: pin_in[1] = 1'b1;
                4'd5: pin_in[1] = 1'b0;
                default: emerg_wake = 1'b1;
            endcase
            @(negedge clk);
            rtc_evt = 1'b0;
            osc_wdog_evt = 1'b0;
            emerg_wake = 1'b0;
            repeat (3) @(negedge clk);
            chk($sformatf("R3/R4/R10 vec%0d in_hib", i), {7'd0, in_hib}, {7'd0, ~VEC[i][5]});
            chk($sformatf("R3/R4/R10 vec%0d status", i), {3'd0, status}, {3'd0, VEC[i][4:0]});
        end

        // R11 sources ignored while active
        do_reset(2'b00);
        wr(2'd0, 7'h01);
        rtc_evt = 1'b1;
        @(negedge clk);
        rtc_evt = 1'b0;
        @(negedge clk);
        chk("R11 status", {3'd0, status}, 8'h00);
        chk("R11 in_hib", {7'd0, in_hib}, 8'h00);

        // R2 entry, R7 default polarity off-level
        wr(2'd0, 7'h21);
        chk("R2 in_hib", {7'd0, in_hib}, 8'h01);
        chk("R7 pin0 released", {6'd0, pin_oe}, 8'h00);
        chk("R2 core_rst_n", {7'd0, core_rst_n}, 8'h00);

        // R3 one-edge exit, R9 reset hold
        rtc_evt = 1'b1;
        @(negedge clk);
        rtc_evt = 1'b0;
        chk("R3 exit", {7'd0, in_hib}, 8'h00);
        chk("R7 pin0 on-level", {6'd0, pin_oe}, 8'h01);
        chk("R3 status", {3'd0, status}, 8'h11);
        repeat (3) @(negedge clk);
        chk("R9 held", {7'd0, core_rst_n}, 8'h00);
        core_pwr_ok = 1'b1;
        @(negedge clk);
        core_pwr_ok = 1'b0;
        chk("R9 release", {7'd0, core_rst_n}, 8'h01);

        // R5 / R6 write-one clear
        wr(2'd2, 7'h01);
        chk("R5 clear rtc", {3'd0, status}, 8'h10);
        wr(2'd2, 7'h10);
        chk("R6 clear flag", {3'd0, status}, 8'h00);

        // R5 set beats clear
        wr(2'd0, 7'h21);
        rtc_evt = 1'b1;
        wr(2'd2, 7'h01);
        rtc_evt = 1'b0;
        chk("R5 set wins", {3'd0, status}, 8'h11);

        // R7 / R8 push-pull with polarity 1
        do_reset(2'b00);
        wr(2'd1, 7'b000_110);
        chk("R8 pp oe", {6'd0, pin_oe}, 8'h01);
        chk("R7 pp on level", {6'd0, pin_out}, 8'h01);
        wr(2'd0, 7'h20);
        chk("R7 pp off level", {6'd0, pin_out}, 8'h00);

        // R12 control on pin 1
        do_reset(2'b00);
        wr(2'd1, 7'b0_101_001);
        wr(2'd0, 7'h40);
        chk("R12 active oe", {6'd0, pin_oe}, 8'h01);
        wr(2'd0, 7'h60);
        chk("R12 hib oe", {6'd0, pin_oe}, 8'h03);
        chk("R8 od out", {6'd0, pin_out}, 8'h00);

        // R4 three-edge latency
        do_reset(2'b00);
        wr(2'd0, 7'h24);
        pin_in[0] = 1'b1;
        @(negedge clk);
        chk("R4 edge+1", {7'd0, in_hib}, 8'h01);
        @(negedge clk);
        chk("R4 edge+2", {7'd0, in_hib}, 8'h01);
        @(negedge clk);
        chk("R4 edge+3", {7'd0, in_hib}, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule